// File: doc/BRIEF.md
# Segmented CPU Address Decoder

This block sits between a 32-bit processor bus and the memory and peripheral targets. Each request carries an address, an access size and a user/kernel mode bit. The decoder strips the segment bits from the address and checks privilege and alignment. It folds mirrored ranges onto their base region and then names exactly one target region, along with an offset measured from that region's base.

The response comes from registers one clock after the request. It holds a one-hot region select, the offset, a cacheable flag and a two-bit error code. Three segments of the address space reach the same 512 MB physical space. Two of them are cached and one is uncached. The fast scratchpad is visible only through the two cached segments. A fourth, kernel-only segment holds nothing except a small window of cache-control registers.

Region bases and sizes come from a table in the package. The offset width and the span of the main-RAM mirror are parameters of the top module.

Top module: `seg_bus_decoder`

## Requirements
- R1: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low. A synchronous active-high `rst` clears `rsp_valid`, `rsp_sel`, `rsp_offset`, `rsp_cacheable` and `rsp_err`.
- R2: Address ranges 00000000h–1FFFFFFFh, 80000000h–9FFFFFFFh and A0000000h–BFFFFFFFh all decode the physical address held in bits 28:0. The same physical address gives the same select and offset through each of these ranges, except for the scratchpad (R5).
- R3: `rsp_cacheable` is 1 for an error-free access through 00000000h–1FFFFFFFh or 80000000h–9FFFFFFFh. It is 0 for A0000000h–BFFFFFFFh, for C0000000h and above, and for every error response.
- R4: Physical addresses below 00800000h select main RAM on `rsp_sel` bit 0. The offset is the physical address modulo 2 MB, so RAM repeats every 2 MB.
- R5: Physical 1F800000h–1F8003FFh selects the scratchpad on bit 2, with offset = address − 1F800000h, when reached through the two cached segments. Reached through A0000000h–BFFFFFFFh, the same range gives a bus error.
- R6: The other physical regions set one select bit each, with offset = address − base:
  - bit 1: 1F000000h–1F7FFFFFh
  - bit 3: 1F801000h–1F801FFFh
  - bit 4: 1F802000h–1F803FFFh (this window wins over the overlapping upper half of the bit-3 window)
  - bit 5: 1FA00000h–1FBFFFFFh
  - bit 6: 1FC00000h–1FC7FFFFh
- R7: At C0000000h and above, only FFFE0000h–FFFE01FFh decodes. It selects bit 7 with offset = address − FFFE0000h. Every other address there gives a bus error.
- R8: A physical address outside every region gives a bus error. This covers 00800000h–1EFFFFFFh, 1F800400h–1F800FFFh, 1F804000h–1F9FFFFFh and 1FC80000h–1FFFFFFFh.
- R9: `req_size` is coded 00 byte, 01 halfword, 10 word, 11 reserved. An address error results from:
  - a halfword access with address bit 0 set;
  - a word access with bits 1:0 nonzero;
  - any access with size 11.
- R10: An address error results from a request with `req_user`=1 and address bit 31 set. It also results from any request to 20000000h–7FFFFFFFh, whatever the mode.
- R11: `rsp_err` is coded 00 none, 01 address error, 10 bus error. An address error is reported instead of a bus error when both apply. On any error, `rsp_sel`, `rsp_offset` and `rsp_cacheable` are all zero.
- R12: An error-free valid response has exactly one bit of `rsp_sel` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Virtual address of the request |
| req_size | input | 2 | Access size code (R9) |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_sel | output | 8 | One-hot region select |
| rsp_offset | output | OFS_W (23) | Offset from the selected region's base |
| rsp_cacheable | output | 1 | Access may be cached |
| rsp_err | output | 2 | Error code (R11) |

## Verification
The bench builds the decoder with its default parameters: a 23-bit offset and a RAM mirror span of 8 MB. With these values every region edge and every gap edge is a small, fixed set of addresses.

Each of those edge addresses is swept through all three low segments, both modes, all four size codes and all four values of the low two address bits. The sweep therefore covers every way that alignment, privilege, scratchpad visibility and bus errors can interact. A similar sweep runs over the high kernel segment and the forbidden upper user range.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

   localparam int NREG = 8;

   localparam int RG_RAM   = 0;
   localparam int RG_EXP1  = 1;
   localparam int RG_SCR   = 2;
   localparam int RG_IO    = 3;
   localparam int RG_EXP2  = 4;
   localparam int RG_EXP3  = 5;
   localparam int RG_BOOT  = 6;
   localparam int RG_CCTL  = 7;

   typedef enum logic [1:0] {
      ERR_NONE = 2'b00,
      ERR_ADDR = 2'b01,
      ERR_BUS  = 2'b10
   } err_e;

   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;
   localparam logic [1:0] SZ_WORD = 2'b10;

   // how a region is reached: any low segment, cached segments only, high kernel segment
   localparam int KIND_PHYS   = 0;
   localparam int KIND_CACHED = 1;
   localparam int KIND_HIGH   = 2;

   localparam logic [31:0] RG_BASE [NREG] = '{
      32'h0000_0000, 32'h1F00_0000, 32'h1F80_0000, 32'h1F80_1000,
      32'h1F80_2000, 32'h1FA0_0000, 32'h1FC0_0000, 32'hFFFE_0000};
   localparam int RG_SIZE_LOG2 [NREG] = '{21, 23, 10, 13, 13, 21, 19, 9};
   localparam int RG_SPAN_LOG2 [NREG] = '{21, 23, 10, 13, 13, 21, 19, 9};
   localparam int RG_KIND [NREG] = '{
      KIND_PHYS, KIND_PHYS, KIND_CACHED, KIND_PHYS,
      KIND_PHYS, KIND_PHYS, KIND_PHYS, KIND_HIGH};

endpackage

// File: rtl/sbd_segment.sv
module sbd_segment (
   input  logic [31:0] addr,
   input  logic        user,
   output logic [28:0] phys,
   output logic        low_path,
   output logic        high_path,
   output logic        cached,
   output logic        fault
);
   always_comb begin
      phys      = addr[28:0];
      low_path  = 1'b0;
      high_path = 1'b0;
      cached    = 1'b0;
      fault     = 1'b0;
      unique case (addr[31:29])
         3'b000: begin
            low_path = 1'b1;
            cached   = 1'b1;
         end
         3'b001, 3'b010, 3'b011: fault = 1'b1;
         3'b100: begin
            fault    = user;
            low_path = !user;
            cached   = !user;
         end
         3'b101: begin
            fault    = user;
            low_path = !user;
         end
         default: begin
            fault     = user;
            high_path = !user;
         end
      endcase
   end
endmodule

// File: rtl/sbd_align.sv
module sbd_align #(
   parameter int SZ_W = 2
) (
   input  logic [SZ_W-1:0] size,
   input  logic [1:0]      lsb,
   output logic            bad
);
   import sbd_pkg::*;

   if (SZ_W != 2) begin : g_bad_width
      $error("sbd_align: size code must be 2 bits");
   end

   always_comb begin
      unique case (size)
         SZ_BYTE: bad = 1'b0;
         SZ_HALF: bad = lsb[0];
         SZ_WORD: bad = |lsb;
         default: bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/sbd_window.sv
module sbd_window #(
   parameter int          AW        = 32,
   parameter logic [31:0] BASE      = 32'h0,
   parameter int          SPAN_LOG2 = 12,
   parameter int          SIZE_LOG2 = 12,
   parameter int          OFS_W     = 23
) (
   input  logic [AW-1:0]    addr,
   input  logic             en,
   output logic             hit,
   output logic [OFS_W-1:0] ofs
);
   if (SIZE_LOG2 > SPAN_LOG2 || SIZE_LOG2 > OFS_W || SPAN_LOG2 >= AW || SIZE_LOG2 < 1) begin : g_bad_cfg
      $error("sbd_window: inconsistent window geometry");
   end

   logic [AW-1:0] delta;
   logic          above;

   assign delta = addr - BASE[AW-1:0];

   if (BASE == 32'h0) begin : g_zero_base
      assign above = 1'b1;
   end else begin : g_offset_base
      assign above = (addr >= BASE[AW-1:0]);
   end

   assign hit = en && above && ((delta >> SPAN_LOG2) == '0);
   assign ofs = OFS_W'(delta[SIZE_LOG2-1:0]);
endmodule

// File: rtl/seg_bus_decoder.sv
module seg_bus_decoder
   import sbd_pkg::*;
#(
   parameter int OFS_W         = 23,
   parameter int RAM_SPAN_LOG2 = 23
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic [31:0]      req_addr,
   input  logic [1:0]       req_size,
   input  logic             req_user,
   output logic             rsp_valid,
   output logic [NREG-1:0]  rsp_sel,
   output logic [OFS_W-1:0] rsp_offset,
   output logic             rsp_cacheable,
   output logic [1:0]       rsp_err
);
   localparam int PHYS_W = 29;

   if (RAM_SPAN_LOG2 < RG_SIZE_LOG2[RG_RAM] || RAM_SPAN_LOG2 >= PHYS_W) begin : g_bad_ram
      $error("seg_bus_decoder: RAM mirror span out of range");
   end

   logic [PHYS_W-1:0] phys;
   logic low_path, high_path, seg_cached, seg_fault, misalign;

   sbd_segment u_seg (
      .addr(req_addr), .user(req_user), .phys(phys),
      .low_path(low_path), .high_path(high_path),
      .cached(seg_cached), .fault(seg_fault));

   sbd_align #(.SZ_W(2)) u_align (
      .size(req_size), .lsb(req_addr[1:0]), .bad(misalign));

   logic [NREG-1:0]  hit;
   logic [OFS_W-1:0] win_ofs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_win
      localparam int SPAN = (g == RG_RAM) ? RAM_SPAN_LOG2 : RG_SPAN_LOG2[g];
      if (RG_SIZE_LOG2[g] > OFS_W) begin : g_bad_ofs
         $error("seg_bus_decoder: offset too narrow for region");
      end
      logic [31:0] w_addr;
      logic        w_en;
      if (RG_KIND[g] == KIND_HIGH) begin : g_high
         assign w_addr = req_addr;
         assign w_en   = high_path;
      end else if (RG_KIND[g] == KIND_CACHED) begin : g_cached
         assign w_addr = {{(32-PHYS_W){1'b0}}, phys};
         assign w_en   = low_path && seg_cached;
      end else begin : g_phys
         assign w_addr = {{(32-PHYS_W){1'b0}}, phys};
         assign w_en   = low_path;
      end
      sbd_window #(
         .AW(32), .BASE(RG_BASE[g]), .SPAN_LOG2(SPAN),
         .SIZE_LOG2(RG_SIZE_LOG2[g]), .OFS_W(OFS_W)
      ) u_win (
         .addr(w_addr), .en(w_en), .hit(hit[g]), .ofs(win_ofs[g]));
   end

   // higher index wins where windows overlap
   logic             pick_any;
   logic [NREG-1:0]  pick_sel;
   logic [OFS_W-1:0] pick_ofs;

   always_comb begin
      pick_any = 1'b0;
      pick_sel = '0;
      pick_ofs = '0;
      for (int i = 0; i < NREG; i++) begin
         if (hit[i]) begin
            pick_any    = 1'b1;
            pick_sel    = '0;
            pick_sel[i] = 1'b1;
            pick_ofs    = win_ofs[i];
         end
      end
   end

   err_e err_n;
   logic addr_err;
   assign addr_err = misalign || seg_fault;

   always_comb begin
      if (addr_err)      err_n = ERR_ADDR;
      else if (!pick_any) err_n = ERR_BUS;
      else               err_n = ERR_NONE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid     <= 1'b0;
         rsp_sel       <= '0;
         rsp_offset    <= '0;
         rsp_cacheable <= 1'b0;
         rsp_err       <= ERR_NONE;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid && err_n == ERR_NONE) begin
            rsp_sel       <= pick_sel;
            rsp_offset    <= pick_ofs;
            rsp_cacheable <= seg_cached;
         end else begin
            rsp_sel       <= '0;
            rsp_offset    <= '0;
            rsp_cacheable <= 1'b0;
         end
         rsp_err <= req_valid ? err_n : ERR_NONE;
      end
   end

   assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> rsp_valid);
   assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !rsp_valid);
   assert_uncached_seg_R3: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_addr[31:29] == 3'b101 |=> !rsp_cacheable);
   assert_word_align_R9: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_size == SZ_WORD && req_addr[1:0] != 2'b00 |=> rsp_err == ERR_ADDR);
   assert_user_kernel_R10: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_user && req_addr[31] |=> rsp_err == ERR_ADDR);
   assert_err_quiet_R11: assert property (@(posedge clk) disable iff (rst)
      rsp_valid && rsp_err != ERR_NONE |-> rsp_sel == '0 && !rsp_cacheable && rsp_offset == '0);
   assert_err_code_R11: assert property (@(posedge clk) disable iff (rst)
      rsp_err != 2'b11);
   assert_onehot_R12: assert property (@(posedge clk) disable iff (rst)
      rsp_valid && rsp_err == ERR_NONE |-> $countones(rsp_sel) == 1);
endmodule

// File: tb/seg_bus_decoder_tb.sv
`timescale 1ns/1ps
module seg_bus_decoder_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_user = 1'b0;
   logic        rsp_valid;
   logic [7:0]  rsp_sel;
   logic [22:0] rsp_offset;
   logic        rsp_cacheable;
   logic [1:0]  rsp_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   seg_bus_decoder #(.OFS_W(23), .RAM_SPAN_LOG2(23)) u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_user(req_user), .rsp_valid(rsp_valid),
      .rsp_sel(rsp_sel), .rsp_offset(rsp_offset),
      .rsp_cacheable(rsp_cacheable), .rsp_err(rsp_err));

   localparam logic [31:0] PROBES [25] = '{
      32'h0000_0000, 32'h001F_FFFC, 32'h0020_0000, 32'h007F_FFFC, 32'h0080_0000,
      32'h1EFF_FFFC, 32'h1F00_0000, 32'h1F7F_FFFC, 32'h1F80_0000, 32'h1F80_03FC,
      32'h1F80_0400, 32'h1F80_0FFC, 32'h1F80_1000, 32'h1F80_1FFC, 32'h1F80_2000,
      32'h1F80_3FFC, 32'h1F80_4000, 32'h1F9F_FFFC, 32'h1FA0_0000, 32'h1FBF_FFFC,
      32'h1FC0_0000, 32'h1FC7_FFFC, 32'h1FC8_0000, 32'h1FFF_FFFC, 32'h0012_3454};
   localparam logic [31:0] SEGS [3] = '{32'h0000_0000, 32'h8000_0000, 32'hA000_0000};
   localparam logic [31:0] HIGH [10] = '{
      32'hC000_0000, 32'hFFFD_FFFC, 32'hFFFE_0000, 32'hFFFE_01FC, 32'hFFFE_0200,
      32'hFFFF_FFFC, 32'hE000_1000, 32'h2000_0000, 32'h5F80_1000, 32'h7FFF_FFFC};

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // expected response computed from the requirements
   function automatic void model(input logic [31:0] a, input logic [1:0] sz, input bit u,
                                 output logic [7:0] s, output logic [22:0] o, output bit c,
                                 output logic [1:0] e, output string rtag, output string etag);
      logic [31:0] p;
      bit k1;
      s = '0; o = '0; c = 1'b0; e = 2'b00;
      rtag = "R11 select/offset";
      etag = "R11 error code";
      if (sz == 2'b11 || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00)) begin
         e = 2'b01; etag = "R9 R11 alignment"; return;
      end
      if (u && a[31]) begin
         e = 2'b01; etag = "R10 user to kernel"; return;
      end
      if (!a[31] && a[30:29] != 2'b00) begin
         e = 2'b01; etag = "R10 upper user range"; return;
      end
      if (a[31:30] == 2'b11) begin
         if (a >= 32'hFFFE_0000 && a <= 32'hFFFE_01FF) begin
            s = 8'h80; o = 23'(a - 32'hFFFE_0000); rtag = "R7 control window";
         end else begin
            e = 2'b10; etag = "R7 high segment";
         end
         return;
      end
      p = {3'b000, a[28:0]};
      k1 = (a[31:29] == 3'b101);
      if (p < 32'h0080_0000) begin
         s = 8'h01; o = 23'(p % 32'h0020_0000); rtag = "R2 R4 RAM";
      end else if (p >= 32'h1F00_0000 && p < 32'h1F80_0000) begin
         s = 8'h02; o = 23'(p - 32'h1F00_0000); rtag = "R2 R6 exp1";
      end else if (p >= 32'h1F80_0000 && p < 32'h1F80_0400) begin
         if (k1) begin
            e = 2'b10; etag = "R5 scratchpad uncached";
         end else begin
            s = 8'h04; o = 23'(p - 32'h1F80_0000); rtag = "R2 R5 scratchpad";
         end
      end else if (p >= 32'h1F80_1000 && p < 32'h1F80_2000) begin
         s = 8'h08; o = 23'(p - 32'h1F80_1000); rtag = "R2 R6 io";
      end else if (p >= 32'h1F80_2000 && p < 32'h1F80_4000) begin
         s = 8'h10; o = 23'(p - 32'h1F80_2000); rtag = "R2 R6 exp2";
      end else if (p >= 32'h1FA0_0000 && p < 32'h1FC0_0000) begin
         s = 8'h20; o = 23'(p - 32'h1FA0_0000); rtag = "R2 R6 exp3";
      end else if (p >= 32'h1FC0_0000 && p < 32'h1FC8_0000) begin
         s = 8'h40; o = 23'(p - 32'h1FC0_0000); rtag = "R2 R6 boot";
      end else begin
         e = 2'b10; etag = "R8 unmapped";
      end
      c = (e == 2'b00) && !k1;
   endfunction

   task automatic apply(input logic [31:0] a, input logic [1:0] sz, input bit u);
      logic [7:0]  s;
      logic [22:0] o;
      bit          c;
      logic [1:0]  e;
      string       rtag, etag;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_size = sz; req_user = u;
      @(negedge clk);
      model(a, sz, u, s, o, c, e, rtag, etag);
      chk(rsp_valid === 1'b1, "R1 valid", 64'(rsp_valid), 64'd1);
      chk(rsp_err === e, etag, 64'(rsp_err), 64'(e));
      chk(rsp_sel === s, rtag, 64'(rsp_sel), 64'(s));
      chk(rsp_offset === o, rtag, 64'(rsp_offset), 64'(o));
      chk(rsp_cacheable === c, "R3 cacheable", 64'(rsp_cacheable), 64'(c));
      if (e == 2'b00)
         chk($countones(rsp_sel) == 1, "R12 one-hot", 64'(rsp_sel), 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(rsp_valid === 1'b0 && rsp_sel === 8'h00 && rsp_err === 2'b00,
          "R1 reset state", 64'({rsp_valid, rsp_sel, rsp_err}), 64'd0);
      @(negedge clk);
      rst = 1'b0;

      for (int pi = 0; pi < 25; pi++)
         for (int si = 0; si < 3; si++)
            for (int ui = 0; ui < 2; ui++)
               for (int sz = 0; sz < 4; sz++)
                  for (int lo = 0; lo < 4; lo++)
                     apply(SEGS[si] | PROBES[pi] | 32'(lo), 2'(sz), ui[0]);

      for (int hi = 0; hi < 10; hi++)
         for (int ui = 0; ui < 2; ui++)
            for (int sz = 0; sz < 4; sz++)
               for (int lo = 0; lo < 4; lo++)
                  apply(HIGH[hi] | 32'(lo), 2'(sz), ui[0]);

      // R1: idle cycle gives no response
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R1 idle", 64'(rsp_valid), 64'd0);
      chk(rsp_sel === 8'h00, "R1 idle select", 64'(rsp_sel), 64'd0);

      // R1: reset during a request clears the response
      req_valid = 1'b1; req_addr = 32'h8000_0100; req_size = 2'b10; req_user = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      chk(rsp_valid === 1'b0 && rsp_sel === 8'h00, "R1 reset mid-run",
          64'({rsp_valid, rsp_sel}), 64'd0);
      req_valid = 1'b0;
      rst = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule